// File: doc/BRIEF.md
# PCI Base Address Window Decoder

This block keeps the base address registers of one PCI configuration header: six ordinary region slots plus an expansion ROM slot. It turns their contents into live address windows. Configuration writes come in as offset, byte length and data. The block claims the ones that target an implemented base register and stores them with the size and type masking applied. Every other write is flagged for forwarding to the ordinary configuration storage, which sits outside this block. A combinational read port returns the stored register for a given offset.

On the decode side, the block compares an incoming I/O address and an incoming memory address against every window. For each region it produces a hit flag and the offset of the address inside the window. The size of each region, whether it is I/O, and whether it is prefetchable are parameters. A window takes part in decoding only when all of the following hold:
- the matching command enable is set;
- its base register has been given a nonzero base;
- its placement is legal for its address space;
- for the ROM slot only, its enable bit is set.

Top module: `bar_window_decoder`

## Requirements
- R1: After reset every base register reads as zero and no region reports a hit, whatever the command enables and addresses are.
- R2: A write is claimed only when its length is 4 and its offset lies in 0x10–0x27 (region index = (offset − 0x10) >> 2) or in 0x30–0x33 (region 6, the ROM slot). The target region must also have a nonzero size.
- R3: A claimed write to regions 0–5 stores (data & ~(size−1)) | type, where type is 0x1 for an I/O region, 0x8 for a prefetchable memory region and 0x0 for any other memory region.
- R4: A claimed write to the ROM slot stores data & (~(size−1) | 1). No type bits are added, and bit 0 is kept as the ROM enable.
- R5: A write that is not claimed leaves every base register unchanged, and cfg_wr_fwd is high during its write cycle. cfg_wr_fwd is low for a claimed write.
- R6: The read port returns the stored value of an implemented region at its offset, with cfg_rd_claim high. For any other offset it returns zero with cfg_rd_claim low.
- R7: An I/O region decodes only while cmd_io_en is high. Memory regions and the ROM decode only while cmd_mem_en is high.
- R8: The ROM window decodes only while bit 0 of its stored register is 1.
- R9: The window base is the stored value & ~(size−1), and a base of zero means unmapped. A region hits when its address lies in base … base+size−1, and its offset output is the address minus the base.
- R10: An I/O window whose last address is above 0xFFFF is unmapped. A window ending exactly at 0xFFFF is mapped.
- R11: A memory window whose end would wrap past 0xFFFFFFFF is unmapped. A window ending exactly at 0xFFFFFFFF is mapped.
- R12: A claimed write takes effect on the clock edge that captures it. During the write cycle, decoding still uses the old window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_offset | input | 8 | Configuration write byte offset |
| cfg_wr_len | input | 3 | Write length in bytes (1, 2 or 4) |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_wr_fwd | output | 1 | Write not claimed, forward to ordinary storage |
| cfg_rd_offset | input | 8 | Configuration read byte offset |
| cfg_rd_data | output | 32 | Stored base register at the read offset |
| cfg_rd_claim | output | 1 | Read offset maps to an implemented region |
| cmd_io_en | input | 1 | Command register I/O space enable |
| cmd_mem_en | input | 1 | Command register memory space enable |
| io_addr | input | 32 | Incoming I/O address |
| mem_addr | input | 32 | Incoming memory address |
| rgn_hit | output | 7 | Per-region hit, bit i for region i |
| rgn_offset | output | 224 | Per-region offset, region i in bits 32i+31:32i |

## Verification
A configuration write that moves a window and a decode of an address inside the old window can fall in the same cycle. The bench drives both from one falling edge. It then judges that the hit and offset follow the old base until the capturing edge, and follow only the new base afterwards. Separately, an I/O address and a memory address are presented together so that an I/O region and the ROM hit in the same cycle. The bench confirms that each region decodes only its own address space and reports its own offset.

// File: rtl/barwin_pkg.sv
package barwin_pkg;
  localparam int NRGN      = 7;
  localparam int ROM_IDX   = 6;
  localparam int AW        = 32;
  localparam int OFS_W     = 8;
  localparam int SLOT_W    = OFS_W - 2;
  localparam logic [SLOT_W-1:0] FIRST_SLOT = 6'h04;  // offset 0x10
  localparam logic [SLOT_W-1:0] ROM_SLOT   = 6'h0C;  // offset 0x30
  localparam logic [AW:0]       IO_TOP     = 33'h0_0000_FFFF;
  localparam logic [AW-1:0]     TYPE_IO    = 32'h1;
  localparam logic [AW-1:0]     TYPE_PREF  = 32'h8;
  typedef logic [AW-1:0] word_t;
endpackage

// File: rtl/barwin_cfg_claim.sv
module barwin_cfg_claim
  import barwin_pkg::*;
#(
  parameter logic [NRGN-1:0][AW-1:0] RGN_SIZE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_offset,
  input  logic [2:0]       wr_len,
  input  logic [OFS_W-1:0] rd_offset,
  output logic [NRGN-1:0]  wr_sel,
  output logic             wr_fwd,
  output logic [NRGN-1:0]  rd_sel,
  output logic             rd_claim
);
  logic [NRGN-1:0] wr_match;
  logic            full_word;

  for (genvar i = 0; i < NRGN; i++) begin : g_slot
    localparam logic [SLOT_W-1:0] SLOT =
      (i == ROM_IDX) ? ROM_SLOT : FIRST_SLOT + SLOT_W'(i);
    localparam logic IMPL = (RGN_SIZE[i] != '0);
    assign wr_match[i] = IMPL && (wr_offset[OFS_W-1:2] == SLOT);
    assign rd_sel[i]   = IMPL && (rd_offset[OFS_W-1:2] == SLOT);
  end

  assign full_word = (wr_len == 3'd4);
  assign wr_sel    = {NRGN{wr_en && full_word}} & wr_match;
  assign wr_fwd    = wr_en && !(|wr_sel);
  assign rd_claim  = |rd_sel;

  // R2
  wr_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));
endmodule

// File: rtl/barwin_bar_bank.sv
module barwin_bar_bank
  import barwin_pkg::*;
#(
  parameter logic [NRGN-1:0][AW-1:0] RGN_SIZE = '0,
  parameter logic [NRGN-1:0]         RGN_IO   = '0,
  parameter logic [NRGN-1:0]         RGN_PREF = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NRGN-1:0]           wr_sel,
  input  word_t                     wr_data,
  input  logic [NRGN-1:0]           rd_sel,
  output logic [NRGN-1:0][AW-1:0]   bar_q,
  output word_t                     rd_data
);
  logic [NRGN-1:0][AW-1:0] bar_d;

  for (genvar i = 0; i < NRGN; i++) begin : g_bar
    localparam word_t SZ_MASK = ~(RGN_SIZE[i] - 32'd1);
    localparam word_t KEEP    = (i == ROM_IDX) ? (SZ_MASK | 32'h1) : SZ_MASK;
    localparam word_t TYPE    = (i == ROM_IDX) ? 32'h0 :
                                RGN_IO[i]      ? TYPE_IO :
                                RGN_PREF[i]    ? TYPE_PREF : 32'h0;

    always_comb begin
      bar_d[i] = (wr_data & KEEP) | TYPE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bar_q[i] <= '0;
      end else if (wr_sel[i]) begin
        bar_q[i] <= bar_d[i];
      end
    end

    // R5
    bar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_sel[i] |=> $stable(bar_q[i]));
    // R3
    bar_lowbits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bar_q[i] & ~KEEP) == 32'h0) || ((bar_q[i] & ~KEEP) == TYPE));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NRGN; i++) begin
      if (rd_sel[i]) rd_data = rd_data | bar_q[i];
    end
  end
endmodule

// File: rtl/barwin_window.sv
module barwin_window
  import barwin_pkg::*;
#(
  parameter word_t SIZE   = 32'h1000,
  parameter bit    IS_IO  = 1'b0,
  parameter bit    IS_ROM = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  word_t bar_q,
  input  logic  space_en,
  input  word_t addr,
  output logic  hit,
  output word_t offset
);
  localparam word_t MASK = ~(SIZE - 32'd1);
  localparam logic  IMPL = (SIZE != '0);

  word_t         base;
  logic [AW:0]   last;
  logic          placed;
  logic          armed;
  logic          mapped;

  always_comb begin
    base   = bar_q & MASK;
    last   = {1'b0, base} + {1'b0, SIZE} - 33'd1;
    placed = IS_IO ? (last <= IO_TOP) : !last[AW];
    armed  = IS_ROM ? bar_q[0] : 1'b1;
    mapped = IMPL && space_en && (base != '0) && placed && armed;
    hit    = mapped && ((addr & MASK) == base);
    offset = addr - base;
  end

  // R7
  space_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !space_en |-> !hit);
  // R9
  offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ({1'b0, offset} < {1'b0, SIZE}));

  if (IS_IO) begin : g_io_chk
    // R10
    io_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ({1'b0, addr} <= IO_TOP));
  end
  if (IS_ROM) begin : g_rom_chk
    // R8
    rom_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> bar_q[0]);
  end
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
  import barwin_pkg::*;
#(
  parameter logic [NRGN-1:0][AW-1:0] RGN_SIZE = {32'h0001_0000, 32'h0,
                                                 32'h0000_0010, 32'h0,
                                                 32'h0001_0000, 32'h0000_0100,
                                                 32'h0000_1000},
  parameter logic [NRGN-1:0]         RGN_IO   = 7'b001_0010,
  parameter logic [NRGN-1:0]         RGN_PREF = 7'b000_0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [7:0]         cfg_wr_offset,
  input  logic [2:0]         cfg_wr_len,
  input  logic [31:0]        cfg_wr_data,
  output logic               cfg_wr_fwd,
  input  logic [7:0]         cfg_rd_offset,
  output logic [31:0]        cfg_rd_data,
  output logic               cfg_rd_claim,
  input  logic               cmd_io_en,
  input  logic               cmd_mem_en,
  input  logic [31:0]        io_addr,
  input  logic [31:0]        mem_addr,
  output logic [6:0]         rgn_hit,
  output logic [7*32-1:0]    rgn_offset
);
  logic [NRGN-1:0]         wr_sel;
  logic [NRGN-1:0]         rd_sel;
  logic [NRGN-1:0][AW-1:0] bar_q;

  barwin_cfg_claim #(.RGN_SIZE(RGN_SIZE)) u_claim (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_offset (cfg_wr_offset),
    .wr_len    (cfg_wr_len),
    .rd_offset (cfg_rd_offset),
    .wr_sel    (wr_sel),
    .wr_fwd    (cfg_wr_fwd),
    .rd_sel    (rd_sel),
    .rd_claim  (cfg_rd_claim)
  );

  barwin_bar_bank #(
    .RGN_SIZE (RGN_SIZE),
    .RGN_IO   (RGN_IO),
    .RGN_PREF (RGN_PREF)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (wr_sel),
    .wr_data (cfg_wr_data),
    .rd_sel  (rd_sel),
    .bar_q   (bar_q),
    .rd_data (cfg_rd_data)
  );

  for (genvar i = 0; i < NRGN; i++) begin : g_win
    localparam bit WIN_IO  = (i != ROM_IDX) && RGN_IO[i];
    localparam bit WIN_ROM = (i == ROM_IDX);
    word_t win_off;

    barwin_window #(
      .SIZE   (RGN_SIZE[i]),
      .IS_IO  (WIN_IO),
      .IS_ROM (WIN_ROM)
    ) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .bar_q    (bar_q[i]),
      .space_en (WIN_IO ? cmd_io_en : cmd_mem_en),
      .addr     (WIN_IO ? io_addr : mem_addr),
      .hit      (rgn_hit[i]),
      .offset   (win_off)
    );
    assign rgn_offset[i*AW +: AW] = win_off;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (rgn_hit == '0));
endmodule

// File: tb/tb_bar_window_decoder.sv
module tb_bar_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wr_offset = '0;
  logic [2:0]  cfg_wr_len = 3'd4;
  logic [31:0] cfg_wr_data = '0;
  logic        cfg_wr_fwd;
  logic [7:0]  cfg_rd_offset = '0;
  logic [31:0] cfg_rd_data;
  logic        cfg_rd_claim;
  logic        cmd_io_en = 1'b0;
  logic        cmd_mem_en = 1'b0;
  logic [31:0] io_addr = '0;
  logic [31:0] mem_addr = '0;
  logic [6:0]  rgn_hit;
  logic [7*32-1:0] rgn_offset;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  bar_window_decoder dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] off(input int i);
    return rgn_offset[i*32 +: 32];
  endfunction

  task automatic cfg_wr(input logic [7:0] o, input logic [2:0] l, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_offset = o; cfg_wr_len = l; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    #1;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] o, input logic [31:0] exp,
                        input logic claim);
    cfg_rd_offset = o;
    #1;
    chk(req, cfg_rd_data, exp);
    chk(req, {31'd0, cfg_rd_claim}, {31'd0, claim});
  endtask

  task automatic t_reset;
    cmd_io_en = 1'b1; cmd_mem_en = 1'b1;
    for (int i = 0; i < 6; i++) rd_chk("R1 bar reads zero", 8'h10 + 8'(4*i), 32'h0, i != 3 && i != 5);
    rd_chk("R1 rom reads zero", 8'h30, 32'h0, 1'b1);
    mem_addr = 32'h0000_0010; io_addr = 32'h0000_0004; #1;
    chk("R1 no hit after reset", {25'd0, rgn_hit}, 32'h0);
  endtask

  task automatic t_masking;
    cfg_wr(8'h10, 3'd4, 32'hFFFF_FFFF);
    rd_chk("R3 mem mask", 8'h10, 32'hFFFF_F000, 1'b1);
    cfg_wr(8'h14, 3'd4, 32'hFFFF_FFFF);
    rd_chk("R3 io type", 8'h14, 32'hFFFF_FF01, 1'b1);
    cfg_wr(8'h18, 3'd4, 32'hFFFF_FFFF);
    rd_chk("R3 prefetch type", 8'h18, 32'hFFFF_0008, 1'b1);
    cfg_wr(8'h30, 3'd4, 32'hFFFF_FFFF);
    rd_chk("R4 rom keeps enable", 8'h30, 32'hFFFF_0001, 1'b1);
    cfg_wr(8'h32, 3'd4, 32'h1234_567E);
    rd_chk("R4 rom mask no type R2 offset 0x32", 8'h30, 32'h1234_0000, 1'b1);
  endtask

  task automatic t_unclaimed;
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_offset = 8'h10; cfg_wr_len = 3'd2; cfg_wr_data = 32'h0; #1;
    chk("R5 short write forwarded", {31'd0, cfg_wr_fwd}, 32'h1);
    @(negedge clk);
    cfg_wr_offset = 8'h1C; cfg_wr_len = 3'd4; #1;
    chk("R2 size-zero region forwarded", {31'd0, cfg_wr_fwd}, 32'h1);
    @(negedge clk);
    cfg_wr_offset = 8'h28; #1;
    chk("R2 offset 0x28 forwarded", {31'd0, cfg_wr_fwd}, 32'h1);
    @(negedge clk);
    cfg_wr_en = 1'b0; #1;
    rd_chk("R5 bar0 untouched", 8'h10, 32'hFFFF_F000, 1'b1);
    rd_chk("R6 size-zero region reads zero", 8'h1C, 32'h0, 1'b0);
    rd_chk("R6 non-bar offset reads zero", 8'h2C, 32'h0, 1'b0);
  endtask

  task automatic t_mem_decode;
    cfg_wr(8'h10, 3'd4, 32'h8000_1000);
    cmd_mem_en = 1'b1; mem_addr = 32'h8000_1234; #1;
    chk("R9 mem hit", {31'd0, rgn_hit[0]}, 32'h1);
    chk("R9 mem offset", off(0), 32'h234);
    mem_addr = 32'h8000_2000; #1;
    chk("R9 just past window", {31'd0, rgn_hit[0]}, 32'h0);
    mem_addr = 32'h8000_1FFF; cmd_mem_en = 1'b0; #1;
    chk("R7 mem disabled", {31'd0, rgn_hit[0]}, 32'h0);
    cmd_mem_en = 1'b1; #1;
    chk("R9 last byte", off(0), 32'hFFF);
    chk("R9 last byte hit", {31'd0, rgn_hit[0]}, 32'h1);
  endtask

  task automatic t_io_decode;
    cfg_wr(8'h14, 3'd4, 32'h0000_C000);
    rd_chk("R3 io stored", 8'h14, 32'h0000_C001, 1'b1);
    cmd_io_en = 1'b1; io_addr = 32'h0000_C0FF; #1;
    chk("R9 io hit", {31'd0, rgn_hit[1]}, 32'h1);
    chk("R9 io offset", off(1), 32'hFF);
    mem_addr = 32'h0000_C0FF; cmd_io_en = 1'b0; #1;
    chk("R7 io disabled, mem addr ignored", {31'd0, rgn_hit[1]}, 32'h0);
    cmd_io_en = 1'b1;
    cfg_wr(8'h14, 3'd4, 32'h0001_0000);
    io_addr = 32'h0001_0010; #1;
    chk("R10 io above 64K unmapped", {31'd0, rgn_hit[1]}, 32'h0);
    cfg_wr(8'h14, 3'd4, 32'h0000_FF00);
    io_addr = 32'h0000_FFFF; #1;
    chk("R10 io ending at 0xFFFF hit", {31'd0, rgn_hit[1]}, 32'h1);
    chk("R10 io offset", off(1), 32'hFF);
  endtask

  task automatic t_rom_and_top;
    cfg_wr(8'h30, 3'd4, 32'hA000_0000);
    mem_addr = 32'hA000_0010; #1;
    chk("R8 rom off", {31'd0, rgn_hit[6]}, 32'h0);
    cfg_wr(8'h30, 3'd4, 32'hA000_0001);
    io_addr = 32'h0000_FF20; #1;
    chk("R8 rom on", {31'd0, rgn_hit[6]}, 32'h1);
    chk("R8 rom offset", off(6), 32'h10);
    chk("R7 io and rom same cycle", {25'd0, rgn_hit}, 32'h42);
    chk("R7 io offset same cycle", off(1), 32'h20);
    cmd_mem_en = 1'b0; #1;
    chk("R7 rom needs mem enable", {31'd0, rgn_hit[6]}, 32'h0);
    cmd_mem_en = 1'b1;
    cfg_wr(8'h18, 3'd4, 32'hFFFF_0000);
    mem_addr = 32'hFFFF_FFFF; #1;
    chk("R11 window ending at top hit", {31'd0, rgn_hit[2]}, 32'h1);
    chk("R11 top offset", off(2), 32'hFFFF);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_offset = 8'h10; cfg_wr_len = 3'd4; cfg_wr_data = 32'h9000_0000;
    mem_addr = 32'h8000_1010; #1;
    chk("R12 old window during write", {31'd0, rgn_hit[0]}, 32'h1);
    chk("R12 old offset", off(0), 32'h10);
    chk("R5 claimed not forwarded", {31'd0, cfg_wr_fwd}, 32'h0);
    @(negedge clk);
    cfg_wr_en = 1'b0; #1;
    chk("R12 old window gone", {31'd0, rgn_hit[0]}, 32'h0);
    mem_addr = 32'h9000_0010; #1;
    chk("R12 new window", {31'd0, rgn_hit[0]}, 32'h1);
    chk("R12 new offset", off(0), 32'h10);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masking();
    t_unclaimed();
    t_mem_decode();
    t_io_decode();
    t_rom_and_top();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule